// File: doc/BRIEF.md
# Ring Interconnect Transfer Allocator

This block decides which transfer may start on a set of one-way data rings that join twelve stops. Each requester presents a source stop, a destination stop and a valid flag, and it holds that request until it receives a grant. In every cycle the allocator takes one candidate. The candidate is the first valid requester in round-robin order after the requester it last served. The allocator picks the travel direction that gives the shorter path. It then looks for a ring of that direction on which every segment of the path is free and which still has room for another transfer. The grant is combinational, so the requester drops its request at the next edge.

A granted transfer holds its segments for a number of beats given at grant time. The rings move at half the core clock, so each beat lasts two core cycles. Transfers whose spans do not overlap share a ring, up to three at a time. A request that names the same stop twice, or a stop that does not exist, is answered at once with an error grant and claims nothing.

Top module: `ring_xfer_alloc`

## Requirements
- R1: Out of reset, no grant is raised while no request is valid, and every bit of the segment busy map is 0.
- R2: At most one bit of `gnt` is high in a cycle, and only for a requester whose `req_vld` bit is high in that cycle. A requester keeps its request up until the cycle of its grant.
- R3: The candidate is the first requester with `req_vld` high, searching upward with wrap-around from the one after the last requester granted (requester 0 first after reset). If the candidate cannot be served, no requester is granted in that cycle.
- R4: A request with source equal to destination, or with either index 12 or above, is granted with `gnt_err` = 1 and `gnt_ring` = 0, and it leaves the busy map unchanged.
- R5: The clockwise hop count is (dst − src) mod 12. If it is 6 or less, only rings 0 and 1 (clockwise) may serve the request. Otherwise only rings 2 and 3 (counter-clockwise) may serve it. `gnt_ring` is 0 when no ring is granted.
- R6: Bit ring·12+k of `seg_busy` is segment k of that ring. On a clockwise ring, segment k joins stop k to stop k+1, and a transfer holds segments src up to dst−1. On a counter-clockwise ring, segment k joins stop k+1 to stop k, and a transfer holds segments dst up to src−1 (all mod 12).
- R7: A ring is granted only if none of the path segments are busy on it. Of the two eligible rings, the lower index is preferred.
- R8: A ring carries at most three transfers at once. A fourth request that fits on no ring waits.
- R9: Segments are busy from the cycle after the grant for 2·B cycles, with B = `xfer_beats` at grant time and 0 taken as 1. They are free again in the next cycle.
- R10: Transfers with disjoint segment spans are granted on the same ring concurrently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | N_REQ | Request valid, one bit per requester |
| req_src | input | N_REQ*4 | Source stop, 4 bits per requester |
| req_dst | input | N_REQ*4 | Destination stop, 4 bits per requester |
| xfer_beats | input | BEAT_W | Transfer length in ring beats, sampled at grant |
| gnt | output | N_REQ | One-hot grant |
| gnt_err | output | 1 | The grant in this cycle rejects a malformed request |
| gnt_ring | output | 2 | Ring chosen for the grant |
| seg_busy | output | N_RINGS*12 | Busy map of all ring segments |

## Verification
The directed part uses several input patterns. A lone bad request separates rejection from a normal grant. A wrap-around clockwise path and a long path that must go counter-clockwise fix the direction rule and the segment numbering. One short transfer, timed cycle by cycle with two beat settings, pins down the release edge. Six short disjoint transfers followed by a seventh show that a ring shares its segments and that capacity is then exhausted. Four requests raised together tell round-robin order apart from fixed priority. A random phase with overlapping paths, bad indices and mixed lengths is compared on every cycle against a queue-based model of active transfers. That phase exposes conflicts, head-of-line waits and pointer updates that the directed patterns do not reach.

// File: rtl/ring_xfer_alloc.sv
module ring_xfer_alloc #(
  parameter int N_REQ   = 4,
  parameter int N_STOPS = 12,
  parameter int N_RINGS = 4,
  parameter int N_SLOTS = 3,
  parameter int BEAT_W  = 4,
  localparam int SW   = $clog2(N_STOPS),
  localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int RW   = $clog2(N_RINGS),
  localparam int SLW  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CW   = BEAT_W + 1,
  localparam int HALF = N_RINGS / 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_REQ-1:0]           req_vld,
  input  logic [N_REQ*SW-1:0]        req_src,
  input  logic [N_REQ*SW-1:0]        req_dst,
  input  logic [BEAT_W-1:0]          xfer_beats,
  output logic [N_REQ-1:0]           gnt,
  output logic                       gnt_err,
  output logic [RW-1:0]              gnt_ring,
  output logic [N_RINGS*N_STOPS-1:0] seg_busy
);

  function automatic logic [N_STOPS-1:0] path_mask(input int s, input int d, input logic cw);
    int hops;
    path_mask = '0;
    hops = cw ? (d - s + N_STOPS) % N_STOPS : (s - d + N_STOPS) % N_STOPS;
    for (int k = 0; k < N_STOPS; k++) begin
      int off;
      off = cw ? (k - s + 2*N_STOPS) % N_STOPS : (s - 1 - k + 2*N_STOPS) % N_STOPS;
      path_mask[k] = (off < hops);
    end
  endfunction

  logic [IW-1:0]                                rr_last;
  logic [N_RINGS-1:0][N_SLOTS-1:0]              s_vld;
  logic [N_RINGS-1:0][N_SLOTS-1:0][N_STOPS-1:0] s_mask;
  logic [N_RINGS-1:0][N_SLOTS-1:0][CW-1:0]      s_cnt;
  logic [N_RINGS-1:0][N_STOPS-1:0]              busy;

  logic              head_vld, bad, use_cw, fire;
  logic [IW-1:0]     head_id;
  logic [SW-1:0]     src, dst;
  logic [N_STOPS-1:0] pmask;
  logic [N_RINGS-1:0] ring_ok;
  logic [RW-1:0]     pick_ring;
  logic [SLW-1:0]    free_slot;
  logic [CW-1:0]     load_cnt;

  always_comb begin
    busy = '0;
    for (int r = 0; r < N_RINGS; r++)
      for (int s = 0; s < N_SLOTS; s++)
        if (s_vld[r][s]) busy[r] = busy[r] | s_mask[r][s];
  end
  assign seg_busy = busy;

  always_comb begin
    head_vld = 1'b0;
    head_id  = '0;
    for (int k = N_REQ; k >= 1; k--) begin
      int idx;
      idx = (int'(rr_last) + k) % N_REQ;
      if (req_vld[idx]) begin
        head_vld = 1'b1;
        head_id  = IW'(idx);
      end
    end
  end

  assign src    = req_src[head_id*SW +: SW];
  assign dst    = req_dst[head_id*SW +: SW];
  assign bad    = (src == dst) || (int'(src) >= N_STOPS) || (int'(dst) >= N_STOPS);
  assign use_cw = ((int'(dst) - int'(src) + N_STOPS) % N_STOPS) <= N_STOPS / 2;
  assign pmask  = path_mask(int'(src), int'(dst), use_cw);

  always_comb begin
    pick_ring = '0;
    for (int r = 0; r < N_RINGS; r++)
      ring_ok[r] = ((r < HALF) == use_cw) && ((busy[r] & pmask) == '0) && !(&s_vld[r]);
    for (int r = N_RINGS-1; r >= 0; r--)
      if (ring_ok[r]) pick_ring = RW'(r);
  end

  always_comb begin
    free_slot = '0;
    for (int s = N_SLOTS-1; s >= 0; s--)
      if (!s_vld[pick_ring][s]) free_slot = SLW'(s);
  end

  assign fire     = head_vld && (bad || (|ring_ok));
  assign gnt      = fire ? (N_REQ'(1) << head_id) : '0;
  assign gnt_err  = fire && bad;
  assign gnt_ring = (fire && !bad) ? pick_ring : '0;
  assign load_cnt = (xfer_beats == '0) ? CW'(2) : {xfer_beats, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_last <= IW'(N_REQ-1);
      s_vld   <= '0;
      s_mask  <= '0;
      s_cnt   <= '0;
    end else begin
      for (int r = 0; r < N_RINGS; r++)
        for (int s = 0; s < N_SLOTS; s++)
          if (s_vld[r][s]) begin
            if (s_cnt[r][s] == CW'(1)) s_vld[r][s] <= 1'b0;
            else                       s_cnt[r][s] <= s_cnt[r][s] - CW'(1);
          end
      if (fire) begin
        rr_last <= head_id;
        if (!bad) begin
          s_vld[pick_ring][free_slot]  <= 1'b1;
          s_mask[pick_ring][free_slot] <= pmask;
          s_cnt[pick_ring][free_slot]  <= load_cnt;
        end
      end
    end
  end

  p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_gnt_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req_vld) == '0);
  p_err_no_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_err |=> (seg_busy & ~$past(seg_busy)) == '0);
  p_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !gnt_err) |-> ((int'(gnt_ring) < HALF) == use_cw));
  p_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !gnt_err) |=> ((busy[$past(gnt_ring)] & $past(pmask)) == $past(pmask)));

endmodule

// File: tb/test_ring_xfer_alloc.sv
`timescale 1ns/1ps
module test_ring_xfer_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req_vld = '0;
  logic [15:0] req_src = '0;
  logic [15:0] req_dst = '0;
  logic [3:0]  xfer_beats = 4'd1;
  logic [3:0]  gnt;
  logic        gnt_err;
  logic [1:0]  gnt_ring;
  logic [47:0] seg_busy;

  ring_xfer_alloc i_ring_xfer_alloc (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_src(req_src), .req_dst(req_dst),
    .xfer_beats(xfer_beats), .gnt(gnt), .gnt_err(gnt_err), .gnt_ring(gnt_ring), .seg_busy(seg_busy));

  always #4 clk = ~clk;

  typedef struct { int ring; bit [11:0] mask; int left; } xfer_t;
  xfer_t act[$];
  int m_last = 3;
  int checks = 0, errors = 0;
  logic [3:0] e_gnt, obs_gnt;
  logic       e_err, obs_err;
  logic [1:0] e_ring, obs_ring;
  bit [11:0]  e_mask;
  int         e_hid;

  function automatic bit [11:0] walk(int s, int d, bit cw);
    bit [11:0] m = '0;
    int k = s;
    while (k != d) begin
      if (cw) begin m[k] = 1'b1; k = (k + 1) % 12; end
      else    begin k = (k + 11) % 12; m[k] = 1'b1; end
    end
    return m;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic model_eval();
    e_gnt = '0; e_err = 1'b0; e_ring = '0; e_mask = '0; e_hid = -1;
    for (int k = 1; k <= 4; k++) begin
      int i = (m_last + k) % 4;
      if (req_vld[i] && e_hid < 0) e_hid = i;
    end
    if (e_hid >= 0) begin
      int s = int'(req_src[e_hid*4 +: 4]);
      int d = int'(req_dst[e_hid*4 +: 4]);
      if (s == d || s > 11 || d > 11) begin
        e_gnt = 4'(1 << e_hid); e_err = 1'b1;
      end else begin
        bit cw = ((d - s + 12) % 12) <= 6;
        int base = cw ? 0 : 2;
        bit [11:0] m = walk(s, d, cw);
        for (int r = base; r < base + 2; r++) begin
          int n = 0;
          bit clash = 1'b0;
          foreach (act[j]) if (act[j].ring == r) begin
            n++;
            if ((act[j].mask & m) != 0) clash = 1'b1;
          end
          if (e_gnt == 0 && n < 3 && !clash) begin
            e_gnt = 4'(1 << e_hid); e_ring = 2'(r); e_mask = m;
          end
        end
      end
    end
  endtask

  function automatic logic [47:0] model_busy();
    logic [47:0] b = '0;
    foreach (act[j]) b[act[j].ring*12 +: 12] = b[act[j].ring*12 +: 12] | act[j].mask;
    return b;
  endfunction

  task automatic cycle();
    #1;
    model_eval();
    chk("R3 gnt", 64'(gnt), 64'(e_gnt));
    chk("R4 gnt_err", 64'(gnt_err), 64'(e_err));
    chk("R7 gnt_ring", 64'(gnt_ring), 64'(e_ring));
    chk("R6 seg_busy", 64'(seg_busy), 64'(model_busy()));
    obs_gnt = gnt; obs_err = gnt_err; obs_ring = gnt_ring;
    for (int j = act.size() - 1; j >= 0; j--) begin
      act[j].left--;
      if (act[j].left == 0) act.delete(j);
    end
    if (e_gnt != 0 && !e_err) begin
      int b = (xfer_beats == 0) ? 1 : int'(xfer_beats);
      act.push_back('{int'(e_ring), e_mask, 2*b});
    end
    if (e_gnt != 0) m_last = e_hid;
    @(negedge clk);
    for (int i = 0; i < 4; i++) if (obs_gnt[i]) req_vld[i] = 1'b0;
  endtask

  task automatic put(int i, int s, int d);
    req_src[i*4 +: 4] = 4'(s);
    req_dst[i*4 +: 4] = 4'(d);
    req_vld[i] = 1'b1;
  endtask

  task automatic drain();
    req_vld = '0;
    for (int n = 0; n < 200 && (seg_busy != 0 || act.size() != 0); n++) cycle();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 gnt idle", 64'(gnt), 0);
    chk("R1 busy clear", 64'(seg_busy), 0);
    @(negedge clk);

    // R4: same stop and nonexistent stop
    put(0, 3, 3); cycle();
    chk("R4 err grant", 64'({obs_gnt, obs_err}), 64'({4'b0001, 1'b1}));
    put(3, 12, 0); cycle();
    chk("R4 err range", 64'({obs_gnt, obs_err}), 64'({4'b1000, 1'b1}));
    chk("R4 no claim", 64'(seg_busy), 0);

    // R5/R6: wrap-around clockwise, then long path counter-clockwise
    xfer_beats = 4'd15;
    put(1, 10, 2); cycle();
    chk("R5 cw ring", 64'(obs_ring), 0);
    chk("R6 cw segs", 64'(seg_busy[11:0]), 64'h C03);
    put(2, 2, 9); cycle();
    chk("R5 ccw ring", 64'(obs_ring), 2);
    chk("R6 ccw segs", 64'(seg_busy[35:24]), 64'h E03);
    drain();

    // R9: hold time with 2 beats and with 0 beats (taken as 1)
    xfer_beats = 4'd2;
    put(0, 0, 1); cycle();
    for (int n = 1; n <= 5; n++) begin
      chk("R9 hold 2 beats", 64'(seg_busy[0]), 64'(n <= 4));
      cycle();
    end
    xfer_beats = 4'd0;
    put(0, 0, 1); cycle();
    for (int n = 1; n <= 3; n++) begin
      chk("R9 hold 0 beats", 64'(seg_busy[0]), 64'(n <= 2));
      cycle();
    end
    drain();

    // R8/R10: six disjoint transfers fill rings 0 and 1, a seventh waits
    xfer_beats = 4'd15;
    for (int p = 0; p < 6; p++) begin
      put(0, 2*p, 2*p + 1); cycle();
      chk("R10 shared ring", 64'(obs_ring), 64'(p / 3));
    end
    chk("R10 ring0 spans", 64'(seg_busy[11:0]), 64'h 015);
    put(0, 1, 2);
    for (int n = 0; n < 3; n++) begin
      cycle();
      chk("R8 capacity wait", 64'(obs_gnt), 0);
    end
    drain();

    // R3: four requests at once are all served, one per cycle
    xfer_beats = 4'd1;
    put(0, 0, 1); put(1, 3, 4); put(2, 6, 7); put(3, 9, 10);
    seen = '0;
    for (int n = 0; n < 4; n++) begin
      cycle();
      seen = seen | obs_gnt;
    end
    chk("R3 round robin", 64'(seen), 64'h F);
    drain();

    // random traffic, R2 held requests, compared each cycle
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 4; i++)
        if (!req_vld[i] && ($urandom % 3) == 0)
          put(i, int'($urandom % 13), int'($urandom % 13));
      xfer_beats = 4'($urandom % 4);
      cycle();
    end
    drain();
    finish_run();
  end
endmodule